// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the system clock. A 5-bit divide code selects the ratio. Codes below 16 divide by the code value. Codes with the top bit set select an even ratio of twice the low four bits, so ratios above 15 come only in steps of two, up to 30. The block also applies clock polarity and clock phase. A late-capture option moves input sampling to the other clock edge, which helps at slow settings where the round trip through the pads is long.

The transfer engine raises `run` to start clocking and lowers it to stop. The clock stops only at the end of a full serial period, so no shortened pulse reaches the bus. The divide code, polarity, phase and late-capture setting are all captured when a transfer starts. For each serial edge the block emits two one-cycle strobes: `launch_stb` tells the shifter to drive the next bit, and `sample_stb` tells it to capture the incoming bit. The block does not shift data, drive chip selects or buffer anything.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While `rst` is high, `sclk` follows the `cpol` input one cycle later, both strobes are low and no transfer is active.
- R2: For a divide code of 2 to 15 with bit 4 clear, the serial period is the code value in system cycles. If the start edge is the clock edge that samples `run` high while idle, the leading `sclk` edge (away from the idle level) appears H = ceil(N/2) edges after the start edge, and the trailing edge appears N edges after it. Both then repeat every N edges.
- R3: Divide codes 0 and 1 both give a ratio of 2, so the serial clock never stalls.
- R4: A code with bit 4 set and low four bits n gives a ratio of 2*n, with n = 0 treated as a ratio of 2. Code 0x1F gives the largest ratio, 30.
- R5: While idle, `sclk` holds the `cpol` level and follows a change of `cpol` one cycle later.
- R6: With `cpha` = 0, `sample_stb` marks the leading edge and `launch_stb` the trailing edge. With `cpha` = 1 the roles swap.
- R7: With `late_capture` = 1, `sample_stb` moves to the other edge of the period, the same edge that carries `launch_stb`. `launch_stb` does not move.
- R8: Each strobe is high for exactly one system cycle, in the cycle where `sclk` takes its new level, and is never high in any other cycle.
- R9: The divide code, `cpol`, `cpha` and `late_capture` are captured at the start edge. Changing them during a transfer has no effect on `sclk` or the strobes until the next transfer.
- R10: When `run` falls, the current period finishes with its trailing edge and the block then goes idle. This holds even if `run` falls in the middle of the period. No further edges or strobes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 5 | Divide code (bit 4 selects the even-step range) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 launches on it |
| late_capture | input | 1 | Moves sampling to the other edge of the period |
| run | input | 1 | Request to clock the serial bus |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe: drive the next output bit |
| sample_stb | output | 1 | One-cycle strobe: capture the input bit |

## Verification
A wrong phase count or a wrong ratio decode moves the very first `sclk` edge of a transfer off its expected cycle. A strobe that lands on the wrong edge breaks the edge-by-edge comparison within one serial period. If the configuration is not captured, the error shows at the first edge after the inputs change in mid-transfer. If the stop logic is wrong, the bench sees an extra pulse or a strobe after the final trailing edge, or a missing trailing edge, within one ratio's worth of cycles after `run` falls.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    localparam int CODE_W    = 5;
    localparam int RATIO_W   = CODE_W;
    localparam int MIN_RATIO = 2;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t ratio;
        ratio_t half;
        logic   cpol;
        logic   cpha;
        logic   late;
    } sclk_cfg_t;

    function automatic ratio_t code_to_ratio(input code_t c);
        ratio_t r;
        if (c[CODE_W-1]) begin
            r = {c[CODE_W-2:0], 1'b0};
        end else begin
            r = ratio_t'(c);
        end
        if (r < ratio_t'(MIN_RATIO)) begin
            r = ratio_t'(MIN_RATIO);
        end
        return r;
    endfunction

    function automatic ratio_t lead_point(input ratio_t r);
        logic [RATIO_W:0] t;
        t = {1'b0, r} + {{RATIO_W{1'b0}}, 1'b1};
        return t[RATIO_W:1];
    endfunction

endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch
    import spi_sclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  code_t     code,
    input  logic      cpol,
    input  logic      cpha,
    input  logic      late,
    output sclk_cfg_t cfg_q
);

    sclk_cfg_t cfg_d;

    always_comb begin
        cfg_d.ratio = code_to_ratio(code);
        cfg_d.half  = lead_point(cfg_d.ratio);
        cfg_d.cpol  = cpol;
        cfg_d.cpha  = cpha;
        cfg_d.late  = late;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ratio <= ratio_t'(MIN_RATIO);
            cfg_q.half  <= lead_point(ratio_t'(MIN_RATIO));
            cfg_q.cpol  <= 1'b0;
            cfg_q.cpha  <= 1'b0;
            cfg_q.late  <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ratio >= ratio_t'(MIN_RATIO)) && (cfg_q.half < cfg_q.ratio)); // R3

endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt
    import spi_sclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  ratio_t ratio,
    input  ratio_t half,
    output logic   active,
    output logic   start,
    output logic   lead_hit,
    output logic   trail_hit
);

    ratio_t cnt_q;
    logic   active_q;

    assign active    = active_q;
    assign start     = run && !active_q;
    assign lead_hit  = active_q && (cnt_q == half - ratio_t'(1));
    assign trail_hit = active_q && (cnt_q == ratio - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            active_q <= run;
            cnt_q    <= '0;
        end else if (trail_hit) begin
            active_q <= run;
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + ratio_t'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q < ratio)); // R2

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (active_q && !trail_hit) |=> active_q); // R10

endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out (
    input  logic clk,
    input  logic rst,
    input  logic cpol_live,
    input  logic cpol_lat,
    input  logic cpha_lat,
    input  logic late_lat,
    input  logic active,
    input  logic lead_hit,
    input  logic trail_hit,
    output logic sclk,
    output logic launch_stb,
    output logic sample_stb
);

    logic sclk_q;
    logic launch_q;
    logic sample_q;
    logic sample_on_trail;

    assign sample_on_trail = cpha_lat ^ late_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= cpol_live;
            launch_q <= 1'b0;
            sample_q <= 1'b0;
        end else begin
            if (lead_hit) begin
                sclk_q <= ~cpol_lat;
            end else if (trail_hit) begin
                sclk_q <= cpol_lat;
            end else if (!active) begin
                sclk_q <= cpol_live;
            end
            launch_q <= cpha_lat ? lead_hit : trail_hit;
            sample_q <= sample_on_trail ? trail_hit : lead_hit;
        end
    end

    assign sclk       = sclk_q;
    assign launch_stb = launch_q;
    assign sample_stb = sample_q;

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (launch_q || sample_q) |-> (sclk_q != $past(sclk_q))); // R8

    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        launch_q |=> !launch_q); // R8

    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sample_q |=> !sample_q); // R8

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> (sclk_q == $past(cpol_live))); // R5

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] div_code,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              late_capture,
    input  logic              run,
    output logic              sclk,
    output logic              launch_stb,
    output logic              sample_stb
);

    sclk_cfg_t cfg_q;
    logic      active;
    logic      start;
    logic      lead_hit;
    logic      trail_hit;

    sclk_cfg_latch u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .code  (div_code),
        .cpol  (cpol),
        .cpha  (cpha),
        .late  (late_capture),
        .cfg_q (cfg_q)
    );

    sclk_phase_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ratio     (cfg_q.ratio),
        .half      (cfg_q.half),
        .active    (active),
        .start     (start),
        .lead_hit  (lead_hit),
        .trail_hit (trail_hit)
    );

    sclk_edge_out u_out (
        .clk        (clk),
        .rst        (rst),
        .cpol_live  (cpol),
        .cpol_lat   (cfg_q.cpol),
        .cpha_lat   (cfg_q.cpha),
        .late_lat   (cfg_q.late),
        .active     (active),
        .lead_hit   (lead_hit),
        .trail_hit  (trail_hit),
        .sclk       (sclk),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(cfg_q)); // R9

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (!launch_stb && !sample_stb)); // R10

endmodule

// File: tb/test_spi_sclk_prescaler.sv
module test_spi_sclk_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] div_code = 5'd4;
    logic       cpol = 1'b1;
    logic       cpha = 1'b0;
    logic       late_capture = 1'b0;
    logic       run = 1'b0;
    logic       sclk;
    logic       launch_stb;
    logic       sample_stb;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    lvl;
        bit    lch;
        bit    smp;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];
    exp_item_t it;

    spi_sclk_prescaler i_spi_sclk_prescaler (
        .clk          (clk),
        .rst          (rst),
        .div_code     (div_code),
        .cpol         (cpol),
        .cpha         (cpha),
        .late_capture (late_capture),
        .run          (run),
        .sclk         (sclk),
        .launch_stb   (launch_stb),
        .sample_stb   (sample_stb)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_ratio(input logic [4:0] c);
        int r;
        if (c[4]) r = 2 * int'(c[3:0]);
        else      r = int'(c);
        if (r < 2) r = 2;
        return r;
    endfunction

    task automatic check_bit(input string req, input string what, input bit got, input bit exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: %s got %0b expected %0b (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // Scoreboard monitor: every sclk edge and strobe is compared in its cycle (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                it = exp_q.pop_front();
                compared++;
                if (sclk !== it.lvl || launch_stb !== it.lch || sample_stb !== it.smp) begin
                    mismatched++;
                    $display("FAIL %s: cycle %0d sclk/launch/sample got %0b%0b%0b expected %0b%0b%0b",
                             it.req, cyc, sclk, launch_stb, sample_stb, it.lvl, it.lch, it.smp);
                end
            end else if (launch_stb || sample_stb) begin
                compared++;
                mismatched++;
                $display("FAIL R8: stray strobe at cycle %0d launch/sample got %0b%0b expected 00",
                         cyc, launch_stb, sample_stb);
            end
        end
    end

    // Driver: starts a transfer and queues the expected edges
    task automatic xfer(input logic [4:0] code, input bit pol, input bit pha, input bit lat,
                        input int periods, input bit scramble, input bit early, input string req);
        int s, n, h, stop_at;
        @(negedge clk);
        div_code = code; cpol = pol; cpha = pha; late_capture = lat; run = 1'b1;
        s = cyc + 1;
        n = exp_ratio(code);
        h = (n + 1) / 2;
        for (int p = 0; p < periods; p++) begin
            exp_q.push_back('{s + p*n + h, ~pol, pha, ~(pha ^ lat), req});
            exp_q.push_back('{s + (p+1)*n, pol, ~pha, pha ^ lat, req});
        end
        stop_at = early ? (s + (periods-1)*n) : (s + periods*n - 1);
        if (scramble) begin
            @(negedge clk);
            div_code = code ^ 5'h1B; cpol = ~pol; cpha = ~pha; late_capture = ~lat;
        end
        while (cyc != stop_at) @(negedge clk);
        run = 1'b0;
        while (cyc != s + periods*n + 2) @(negedge clk);
        check_bit(req, "idle sclk after stop", sclk, cpol);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1", "sclk in reset", sclk, 1'b1);
        check_bit("R1", "launch in reset", launch_stb, 1'b0);
        check_bit("R1", "sample in reset", sample_stb, 1'b0);
        cpol = 1'b0;
        @(negedge clk);
        check_bit("R1", "sclk follows cpol in reset", sclk, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R5: idle level follows cpol
        cpol = 1'b1;
        @(negedge clk);
        check_bit("R5", "idle sclk after cpol=1", sclk, 1'b1);
        cpol = 1'b0;
        @(negedge clk);
        check_bit("R5", "idle sclk after cpol=0", sclk, 1'b0);

        // R2/R6: direct codes, both phases, odd ratio
        xfer(5'd4,  1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R2");
        xfer(5'd7,  1'b0, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R6");
        xfer(5'd2,  1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R6");
        xfer(5'd15, 1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b0, "R2");
        // R3: codes 0 and 1 clamp to 2
        xfer(5'd0,  1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R3");
        xfer(5'd1,  1'b1, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R3");
        // R4: even-step range
        xfer(5'h13, 1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R4");
        xfer(5'h1F, 1'b0, 1'b1, 1'b0, 2, 1'b0, 1'b0, "R4");
        xfer(5'h10, 1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R4");
        // R7: late capture with both phases
        xfer(5'd6,  1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0, "R7");
        xfer(5'd3,  1'b1, 1'b1, 1'b1, 3, 1'b0, 1'b0, "R7");
        // R9: inputs change mid-transfer
        xfer(5'd5,  1'b0, 1'b0, 1'b0, 4, 1'b1, 1'b0, "R9");
        xfer(5'h14, 1'b1, 1'b1, 1'b1, 3, 1'b1, 1'b0, "R9");
        // R10: run drops mid-period
        xfer(5'd9,  1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b1, "R10");
        xfer(5'd2,  1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b1, "R10");

        repeat (40) @(negedge clk);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R8: %0d expected edges never seen, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule